// File: doc/BRIEF.md
# Synthesizer Configuration Port

This block keeps the divider and test settings of a clock synthesizer and lets them be written along two paths. A parallel path copies a 9-bit feedback divider value and a 2-bit output divider select straight from input pins when its strobe rises. A three-wire serial path clocks a 14-bit word into a shift register, one bit per serial clock rise. When the serial strobe falls, the whole word is moved into the settings. That word carries the feedback divider, the output divider select and a 3-bit test select.

All pins are brought into one system clock through two-flop synchronizers, and their edges are found in that clock. The system clock must run at least four times faster than the serial clock. The parallel path always wins: a serial load is refused while the synchronized parallel strobe is low, and it is also refused when a parallel load falls in the same cycle. Each accepted load raises a single-cycle update pulse, which tells the downstream dividers to reload.

Top module: `synth_cfg_port`

## Requirements
- R1: While reset is asserted, cfg_m reads 0x1FF, cfg_n reads 0x3, cfg_t reads 0x7 and cfg_updated is 0.
- R2: A low-to-high change of par_load copies par_m into cfg_m and par_n into cfg_n, and leaves cfg_t unchanged. While par_load stays high, later changes on par_m and par_n have no effect.
- R3: Each rising edge of ser_clk shifts ser_data into bit 0 of a 14-bit register, so the first bit sent ends in bit 13. Bits 13..11 are the test select, bits 10..9 are the output divider select, and bits 8..0 are the feedback divider.
- R4: A high-to-low change of ser_load, while par_load is high, copies the whole shift register into cfg_t, cfg_n and cfg_m.
- R5: A falling ser_load while par_load is low leaves all outputs unchanged and gives no update pulse.
- R6: If a par_load rise and a ser_load fall are detected in the same cycle, only the parallel load takes place, and cfg_t keeps its value.
- R7: Every accepted load gives exactly one cfg_updated pulse, one system clock wide. The outputs never change without such a pulse.
- R8: Reset clears the shift register, so a serial load with no bits shifted in since reset sets all three outputs to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| par_m | input | 9 | Feedback divider value on the parallel pins |
| par_n | input | 2 | Output divider select on the parallel pins |
| par_load | input | 1 | Parallel strobe; a rising edge loads |
| ser_clk | input | 1 | Serial shift clock |
| ser_data | input | 1 | Serial data, most significant bit first |
| ser_load | input | 1 | Serial strobe; a falling edge loads |
| cfg_m | output | 9 | Current feedback divider value |
| cfg_n | output | 2 | Current output divider select |
| cfg_t | output | 3 | Current test select |
| cfg_updated | output | 1 | One-cycle pulse after each accepted load |

## Verification
A parallel strobe rise and a serial strobe fall can be detected in the same system clock cycle. The bench provokes this by changing both pins on the same falling clock edge, after a word with a different test field has been shifted in. Both pins pass through synchronizers of equal depth, so their edges are found in the same cycle. The result is correct when the divider fields match the parallel pins, the test field keeps its old value, and the update pulse counter goes up by exactly one.

// File: rtl/synth_cfg_pkg.sv
package synth_cfg_pkg;
    localparam int M_W    = 9;
    localparam int N_W    = 2;
    localparam int T_W    = 3;
    localparam int WORD_W = T_W + N_W + M_W;

    // synchronizer channel indices
    localparam int SYN_SCLK = 0;
    localparam int SYN_SDAT = 1;
    localparam int SYN_SLD  = 2;
    localparam int SYN_PLD  = 3;
    localparam int SYN_W    = 4;
    localparam int SYN_STAGES = 2;

    // field order matches the serial word: test select on top, divider at bit 0
    typedef struct packed {
        logic [T_W-1:0] t;
        logic [N_W-1:0] n;
        logic [M_W-1:0] m;
    } cfg_word_t;

    typedef struct packed {
        cfg_word_t cfg;
        logic      upd;
    } cfg_state_t;
endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] lvl,
    output logic [WIDTH-1:0] rise,
    output logic [WIDTH-1:0] fall
);
    // STAGES synchronizing flops plus one history flop for edge detection
    logic [STAGES:0][WIDTH-1:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d[0] = din;
        for (int i = 1; i <= STAGES; i++) begin
            pipe_d[i] = pipe_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= pipe_d;
    end

    assign lvl  = pipe_q[STAGES-1];
    assign rise = pipe_q[STAGES-1] & ~pipe_q[STAGES];
    assign fall = ~pipe_q[STAGES-1] & pipe_q[STAGES];
endmodule

// File: rtl/cfg_shifter.sv
module cfg_shifter #(
    parameter int WIDTH = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shift_en,
    input  logic             bit_in,
    output logic [WIDTH-1:0] word
);
    logic [WIDTH-1:0] sr_d, sr_q;

    always_comb begin
        sr_d = sr_q;
        if (shift_en) sr_d = {sr_q[WIDTH-2:0], bit_in};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr_q <= '0;
        else        sr_q <= sr_d;
    end

    assign word = sr_q;
endmodule

// File: rtl/synth_cfg_port.sv
module synth_cfg_port
    import synth_cfg_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic [M_W-1:0] par_m,
    input  logic [N_W-1:0] par_n,
    input  logic           par_load,
    input  logic           ser_clk,
    input  logic           ser_data,
    input  logic           ser_load,
    output logic [M_W-1:0] cfg_m,
    output logic [N_W-1:0] cfg_n,
    output logic [T_W-1:0] cfg_t,
    output logic           cfg_updated
);
    logic [SYN_W-1:0]  syn_in, syn_lvl, syn_rise, syn_fall;
    logic [WORD_W-1:0] shift_word;
    logic              par_rise, par_hi, ser_fall, ser_shift;
    cfg_state_t        st_d, st_q;

    assign syn_in[SYN_SCLK] = ser_clk;
    assign syn_in[SYN_SDAT] = ser_data;
    assign syn_in[SYN_SLD]  = ser_load;
    assign syn_in[SYN_PLD]  = par_load;

    cfg_sync #(.WIDTH(SYN_W), .STAGES(SYN_STAGES)) i_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (syn_in),
        .lvl  (syn_lvl),
        .rise (syn_rise),
        .fall (syn_fall)
    );

    assign ser_shift = syn_rise[SYN_SCLK];
    assign ser_fall  = syn_fall[SYN_SLD];
    assign par_rise  = syn_rise[SYN_PLD];
    assign par_hi    = syn_lvl[SYN_PLD];

    cfg_shifter #(.WIDTH(WORD_W)) i_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .shift_en(ser_shift),
        .bit_in  (syn_lvl[SYN_SDAT]),
        .word    (shift_word)
    );

    always_comb begin
        st_d     = st_q;
        st_d.upd = 1'b0;
        if (par_rise) begin
            // parallel path wins; test select is kept
            st_d.cfg.m = par_m;
            st_d.cfg.n = par_n;
            st_d.upd   = 1'b1;
        end else if (ser_fall && par_hi) begin
            st_d.cfg = cfg_word_t'(shift_word);
            st_d.upd = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cfg <= '1;
            st_q.upd <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cfg_m       = st_q.cfg.m;
    assign cfg_n       = st_q.cfg.n;
    assign cfg_t       = st_q.cfg.t;
    assign cfg_updated = st_q.upd;
endmodule

// File: rtl/synth_cfg_checker.sv
module synth_cfg_checker
    import synth_cfg_pkg::*;
(
    input logic           clk,
    input logic           rst_n,
    input logic [M_W-1:0] par_m,
    input logic [N_W-1:0] par_n,
    input logic           par_rise,
    input logic           par_hi,
    input logic           ser_fall,
    input logic [M_W-1:0] cfg_m,
    input logic [N_W-1:0] cfg_n,
    input logic [T_W-1:0] cfg_t,
    input logic           cfg_updated
);
    assert_reset_values_R1: assert property (@(posedge clk)
        !rst_n |=> (cfg_m == '1 && cfg_n == '1 && cfg_t == '1 && !cfg_updated));

    assert_par_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
        par_rise |=> (cfg_m == $past(par_m) && cfg_n == $past(par_n) && $stable(cfg_t)));

    assert_ser_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_fall && !par_hi && !par_rise) |=> ($stable(cfg_t) && $stable(cfg_m) && !cfg_updated));

    assert_par_priority_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (par_rise && ser_fall) |=> $stable(cfg_t));

    assert_change_has_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(cfg_m) || !$stable(cfg_n) || !$stable(cfg_t)) |-> cfg_updated);

    assert_load_gives_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (par_rise || (ser_fall && par_hi)) |=> cfg_updated);
endmodule

bind synth_cfg_port synth_cfg_checker i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .par_m      (par_m),
    .par_n      (par_n),
    .par_rise   (par_rise),
    .par_hi     (par_hi),
    .ser_fall   (ser_fall),
    .cfg_m      (cfg_m),
    .cfg_n      (cfg_n),
    .cfg_t      (cfg_t),
    .cfg_updated(cfg_updated)
);

// File: tb/test_synth_cfg_port.sv
module test_synth_cfg_port;
    import synth_cfg_pkg::*;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [M_W-1:0] par_m = 9'h0A5;
    logic [N_W-1:0] par_n = 2'b01;
    logic           par_load = 1'b0;
    logic           ser_clk = 1'b0;
    logic           ser_data = 1'b0;
    logic           ser_load = 1'b0;
    logic [M_W-1:0] cfg_m;
    logic [N_W-1:0] cfg_n;
    logic [T_W-1:0] cfg_t;
    logic           cfg_updated;

    int n_checks = 0;
    int n_fails  = 0;
    int pulses   = 0;
    int wide_pulses = 0;
    logic prev_upd = 1'b0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    synth_cfg_port i_synth_cfg_port (
        .clk(clk), .rst_n(rst_n), .par_m(par_m), .par_n(par_n), .par_load(par_load),
        .ser_clk(ser_clk), .ser_data(ser_data), .ser_load(ser_load),
        .cfg_m(cfg_m), .cfg_n(cfg_n), .cfg_t(cfg_t), .cfg_updated(cfg_updated)
    );

    always @(negedge clk) begin
        if (cfg_updated) pulses++;
        if (cfg_updated && prev_upd) wide_pulses++;
        prev_upd = cfg_updated;
    end

    localparam int NVEC = 6;
    localparam logic [WORD_W-1:0] VEC [NVEC] = '{
        14'h2AAA, 14'h1555, 14'h3FFF, 14'h0001, 14'h2000, 14'h1A3C
    };

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_word(input logic [WORD_W-1:0] w);
        for (int i = WORD_W - 1; i >= 0; i--) begin
            ser_data = w[i];
            ser_clk  = 1'b0;
            wait_cyc(4);
            ser_clk  = 1'b1;
            wait_cyc(4);
        end
        ser_clk = 1'b0;
        wait_cyc(4);
    endtask

    task automatic ser_strobe();
        ser_load = 1'b1;
        wait_cyc(5);
        ser_load = 1'b0;
        wait_cyc(6);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fails++;
            n_checks++;
            $display("FAIL watchdog: actual 0x0 expected 0x1");
            summary();
        end
    end

    initial begin
        int p0;
        logic [T_W-1:0] t_keep;
        wait_cyc(5);
        // R1: reset values
        check("R1 m", cfg_m, 9'h1FF);
        check("R1 n", cfg_n, 2'h3);
        check("R1 t", cfg_t, 3'h7);
        check("R1 upd", cfg_updated, 0);
        rst_n = 1'b1;
        wait_cyc(6);
        check("R1 m after release", cfg_m, 9'h1FF);

        // R5: serial strobe while parallel strobe low is ignored
        p0 = pulses;
        ser_strobe();
        check("R5 m", cfg_m, 9'h1FF);
        check("R5 t", cfg_t, 3'h7);
        check("R5 pulses", pulses - p0, 0);

        // R2: parallel rise captures pins, test select kept
        p0 = pulses;
        par_load = 1'b1;
        wait_cyc(6);
        check("R2 m", cfg_m, 9'h0A5);
        check("R2 n", cfg_n, 2'h1);
        check("R2 t", cfg_t, 3'h7);
        check("R7 par pulse", pulses - p0, 1);
        // R2: pin changes while strobe stays high have no effect
        par_m = 9'h111;
        par_n = 2'b10;
        wait_cyc(6);
        check("R2 held m", cfg_m, 9'h0A5);
        check("R2 held n", cfg_n, 2'h1);

        // R8: load with nothing shifted since reset gives zero
        ser_strobe();
        check("R8 m", cfg_m, 0);
        check("R8 n", cfg_n, 0);
        check("R8 t", cfg_t, 0);

        // R3 / R4 / R7: table of serial words
        for (int v = 0; v < NVEC; v++) begin
            p0 = pulses;
            send_word(VEC[v]);
            check("R3 m unchanged before strobe", cfg_m, (v == 0) ? 0 : int'(VEC[v-1][8:0]));
            ser_strobe();
            check("R4 m", cfg_m, VEC[v][8:0]);
            check("R4 n", cfg_n, VEC[v][10:9]);
            check("R3 t", cfg_t, VEC[v][13:11]);
            check("R7 ser pulse", pulses - p0, 1);
        end

        // R5: word shifted and strobed while parallel strobe low
        par_load = 1'b0;
        wait_cyc(6);
        p0 = pulses;
        send_word(14'h0C33);
        ser_strobe();
        check("R5 low m", cfg_m, VEC[NVEC-1][8:0]);
        check("R5 low t", cfg_t, VEC[NVEC-1][13:11]);
        check("R5 low pulses", pulses - p0, 0);

        // R6: parallel rise and serial fall in the same cycle
        t_keep = cfg_t;
        par_m = 9'h07E;
        par_n = 2'b11;
        ser_load = 1'b1;
        wait_cyc(6);
        p0 = pulses;
        par_load = 1'b1;
        ser_load = 1'b0;
        wait_cyc(6);
        check("R6 m", cfg_m, 9'h07E);
        check("R6 n", cfg_n, 2'h3);
        check("R6 t", cfg_t, t_keep);
        check("R6 pulses", pulses - p0, 1);

        // R7: every pulse exactly one cycle wide
        check("R7 width", wide_pulses, 0);

        done = 1'b1;
        summary();
    end
endmodule